// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the fifteen general-purpose registers (indices 0 to 14) of a processor core that runs in several privilege modes, plus one saved status word for each exception mode. The block keeps the active mode itself. The core asks for a mode switch through a request strobe and a 5-bit mode code. From then on, reads and writes by logical index land on the physical copies that belong to that mode.

Registers 13 and 14 have a separate copy in each of six banks. The unprivileged mode and the privileged system mode share bank 0. The fast-interrupt mode also has private copies of registers 8 to 12. All other modes share one copy of those registers. Registers 0 to 7 exist only once.

The block keeps the visible copies in a single working array. On a mode switch it saves the outgoing copies into a shadow store and loads the incoming ones. Reads therefore come from one small array through a flat multiplexer.

Top module: `banked_regfile`

## Requirements
- R1: Synchronous active-high reset clears every register and saved status word. It also sets the active mode to Supervisor (5'b10011) and clears the error flag.
- R2: Registers 0 to 7 have one copy that every mode sees. A write appears on both read ports from the next cycle on.
- R3: Each mode's bank keeps its own copies of registers 13 and 14. The mode codes and their banks are:
  - User 5'b10000 and System 5'b11111: bank 0 (shared)
  - FIQ 5'b10001: bank 1
  - IRQ 5'b10010: bank 2
  - Supervisor 5'b10011: bank 3
  - Abort 5'b10111: bank 4
  - Undefined 5'b11011: bank 5
- R4: Registers 8 to 12 have one copy for FIQ mode and one copy shared by all other modes.
- R5: A mode request with a legal code moves the active mode to that code at the next clock edge. After a round trip through other modes, each bank's values are found unchanged.
- R6: A register write in the same cycle as a mode switch lands in the bank of the mode that was active before the switch.
- R7: Each of the five exception modes has its own saved status word. The read port returns the word of the active mode, and the write port updates that word.
- R8: In User or System mode the saved-status read port returns zero, and a write to it has no effect.
- R9: A mode request with any other code leaves the mode and all registers as they were. It raises `mode_err` for exactly the following cycle.
- R10: Index 15 reads as zero, and a write to index 15 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_chg | input | 1 | Mode switch request |
| mode_new | input | 5 | Requested mode code |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | DW | Read port A data |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | DW | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Register write index |
| wr_data | input | DW | Register write data |
| sr_wr_en | input | 1 | Saved status write enable |
| sr_wr_data | input | SRW | Saved status write data |
| sr_rd_data | output | SRW | Saved status word of the active mode |
| mode_cur | output | 5 | Active mode code |
| mode_err | output | 1 | Last request carried an illegal code |

## Verification
The bench targets several corner cases:
- A write in the same cycle as a mode switch. A design that applied it after the swap would plant the value in the new bank.
- Round trips between User and System. A design that banks them apart would lose register 13 across the pair.
- Entering and leaving FIQ. A wrong split would make registers 8 to 12 leak between FIQ and the other modes.
- Illegal mode codes and writes to the saved status word in modes that have none. A careless design would corrupt state or flip the mode.

A flat model of the physical slots runs alongside the design and catches any cross-bank leak on the read ports, cycle by cycle.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
    localparam int MODE_W    = 5;
    localparam int NUM_LOG   = 15;
    localparam int IDX_W     = 4;
    localparam int NUM_BANKS = 6;
    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int NUM_SR    = NUM_BANKS - 1;
    localparam int SR_IDX_W  = $clog2(NUM_SR);
    localparam int HI_FIRST  = 8;
    localparam int HI_CNT    = 5;
    localparam int SP_FIRST  = HI_FIRST + HI_CNT;
    localparam int SP_CNT    = NUM_LOG - SP_FIRST;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef struct packed {
        logic [BANK_W-1:0]   bank;
        logic                fiq;
        logic                has_sr;
        logic [SR_IDX_W-1:0] sr_idx;
    } bank_sel_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic [BANK_W-1:0] bank_of(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_W'(1);
            MODE_IRQ: return BANK_W'(2);
            MODE_SVC: return BANK_W'(3);
            MODE_ABT: return BANK_W'(4);
            MODE_UND: return BANK_W'(5);
            default:  return BANK_W'(0);
        endcase
    endfunction

    function automatic bank_sel_t decode_mode(input logic [MODE_W-1:0] m);
        bank_sel_t s;
        s.bank   = bank_of(m);
        s.fiq    = (m == MODE_FIQ);
        s.has_sr = (s.bank != '0);
        s.sr_idx = s.has_sr ? SR_IDX_W'(s.bank - BANK_W'(1)) : '0;
        return s;
    endfunction
endpackage

// File: rtl/bank_mode_ctrl.sv
`timescale 1ns/1ps
module bank_mode_ctrl
    import bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_chg,
    input  logic [MODE_W-1:0] mode_new,
    output logic [MODE_W-1:0] mode_cur,
    output bank_sel_t         cur_sel,
    output logic [BANK_W-1:0] nxt_bank,
    output logic              nxt_fiq,
    output logic              sp_swap,
    output logic              hi_swap,
    output logic              mode_err
);
    logic accept;

    always_comb begin
        cur_sel  = decode_mode(mode_cur);
        nxt_bank = bank_of(mode_new);
        nxt_fiq  = (mode_new == MODE_FIQ);
        accept   = mode_chg && mode_legal(mode_new);
        sp_swap  = accept && (nxt_bank != cur_sel.bank);
        hi_swap  = accept && (nxt_fiq != cur_sel.fiq);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_cur <= MODE_SVC;
            mode_err <= 1'b0;
        end else begin
            if (accept)
                mode_cur <= mode_new;
            mode_err <= mode_chg && !mode_legal(mode_new);
        end
    end
endmodule

// File: rtl/bank_shadow_store.sv
`timescale 1ns/1ps
module bank_shadow_store
    import bank_pkg::*;
#(
    parameter int DW = 32
)(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sp_swap,
    input  logic                         hi_swap,
    input  logic [BANK_W-1:0]            old_bank,
    input  logic [BANK_W-1:0]            new_bank,
    input  logic                         old_fiq,
    input  logic                         new_fiq,
    input  logic [SP_CNT-1:0][DW-1:0]    sp_save,
    input  logic [HI_CNT-1:0][DW-1:0]    hi_save,
    output logic [SP_CNT-1:0][DW-1:0]    sp_load,
    output logic [HI_CNT-1:0][DW-1:0]    hi_load
);
    localparam int HI_SETS = 2;

    logic [SP_CNT-1:0][DW-1:0] sp_mem [NUM_BANKS];
    logic [HI_CNT-1:0][DW-1:0] hi_mem [HI_SETS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sp
        always_ff @(posedge clk) begin
            if (rst)
                sp_mem[b] <= '0;
            else if (sp_swap && old_bank == BANK_W'(b))
                sp_mem[b] <= sp_save;
        end
    end

    for (genvar f = 0; f < HI_SETS; f++) begin : g_hi
        always_ff @(posedge clk) begin
            if (rst)
                hi_mem[f] <= '0;
            else if (hi_swap && old_fiq == 1'(f))
                hi_mem[f] <= hi_save;
        end
    end

    always_comb begin
        sp_load = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (new_bank == BANK_W'(b))
                sp_load = sp_mem[b];
        hi_load = new_fiq ? hi_mem[1] : hi_mem[0];
    end
endmodule

// File: rtl/spsr_file.sv
`timescale 1ns/1ps
module spsr_file
    import bank_pkg::*;
#(
    parameter int SRW = 32
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                has_sr,
    input  logic [SR_IDX_W-1:0] sr_idx,
    input  logic [SRW-1:0]      wr_data,
    output logic [SRW-1:0]      rd_data
);
    logic [SRW-1:0] sr_mem [NUM_SR];

    for (genvar k = 0; k < NUM_SR; k++) begin : g_sr
        always_ff @(posedge clk) begin
            if (rst)
                sr_mem[k] <= '0;
            else if (wr_en && has_sr && sr_idx == SR_IDX_W'(k))
                sr_mem[k] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SR; k++)
            if (has_sr && sr_idx == SR_IDX_W'(k))
                rd_data = sr_mem[k];
    end
endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
    import bank_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SRW = 32
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_chg,
    input  logic [MODE_W-1:0] mode_new,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DW-1:0]     rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DW-1:0]     rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              sr_wr_en,
    input  logic [SRW-1:0]    sr_wr_data,
    output logic [SRW-1:0]    sr_rd_data,
    output logic [MODE_W-1:0] mode_cur,
    output logic              mode_err
);
    bank_sel_t           cur_sel;
    logic [BANK_W-1:0]   nxt_bank;
    logic                nxt_fiq;
    logic                sp_swap;
    logic                hi_swap;

    logic [DW-1:0]             vis    [NUM_LOG];
    logic [DW-1:0]             merged [NUM_LOG];
    logic [SP_CNT-1:0][DW-1:0] sp_save, sp_load;
    logic [HI_CNT-1:0][DW-1:0] hi_save, hi_load;

    bank_mode_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_chg (mode_chg),
        .mode_new (mode_new),
        .mode_cur (mode_cur),
        .cur_sel  (cur_sel),
        .nxt_bank (nxt_bank),
        .nxt_fiq  (nxt_fiq),
        .sp_swap  (sp_swap),
        .hi_swap  (hi_swap),
        .mode_err (mode_err)
    );

    // The write is merged before saving, so it lands in the outgoing bank (R6)
    always_comb begin
        for (int i = 0; i < NUM_LOG; i++)
            merged[i] = (wr_en && wr_idx == IDX_W'(i)) ? wr_data : vis[i];
        for (int j = 0; j < SP_CNT; j++)
            sp_save[j] = merged[SP_FIRST + j];
        for (int j = 0; j < HI_CNT; j++)
            hi_save[j] = merged[HI_FIRST + j];
    end

    bank_shadow_store #(.DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .sp_swap  (sp_swap),
        .hi_swap  (hi_swap),
        .old_bank (cur_sel.bank),
        .new_bank (nxt_bank),
        .old_fiq  (cur_sel.fiq),
        .new_fiq  (nxt_fiq),
        .sp_save  (sp_save),
        .hi_save  (hi_save),
        .sp_load  (sp_load),
        .hi_load  (hi_load)
    );

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LOG; i++) begin
            if (rst)
                vis[i] <= '0;
            else if (i >= SP_FIRST)
                vis[i] <= sp_swap ? sp_load[i - SP_FIRST] : merged[i];
            else if (i >= HI_FIRST)
                vis[i] <= hi_swap ? hi_load[i - HI_FIRST] : merged[i];
            else
                vis[i] <= merged[i];
        end
    end

    always_comb begin
        rd_a_data = '0;
        rd_b_data = '0;
        for (int i = 0; i < NUM_LOG; i++) begin
            if (rd_a_idx == IDX_W'(i)) rd_a_data = vis[i];
            if (rd_b_idx == IDX_W'(i)) rd_b_data = vis[i];
        end
    end

    spsr_file #(.SRW(SRW)) u_spsr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sr_wr_en),
        .has_sr  (cur_sel.has_sr),
        .sr_idx  (cur_sel.sr_idx),
        .wr_data (sr_wr_data),
        .rd_data (sr_rd_data)
    );
endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk
    import bank_pkg::*;
#(
    parameter int DW  = 32,
    parameter int SRW = 32
)(
    input logic              clk,
    input logic              rst,
    input logic              mode_chg,
    input logic [MODE_W-1:0] mode_new,
    input logic [IDX_W-1:0]  rd_a_idx,
    input logic [DW-1:0]     rd_a_data,
    input logic [IDX_W-1:0]  rd_b_idx,
    input logic [DW-1:0]     rd_b_data,
    input logic              wr_en,
    input logic              sr_wr_en,
    input logic [SRW-1:0]    sr_rd_data,
    input logic [MODE_W-1:0] mode_cur,
    input logic              mode_err
);
    assert_mode_follow_R5: assert property (@(posedge clk) disable iff (rst)
        mode_chg && mode_legal(mode_new) |=> mode_cur == $past(mode_new));

    assert_mode_valid_R5: assert property (@(posedge clk) disable iff (rst)
        mode_legal(mode_cur));

    assert_bad_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        mode_chg && !mode_legal(mode_new) |=> mode_err && $stable(mode_cur));

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !(mode_chg && !mode_legal(mode_new)) |=> !mode_err);

    assert_sr_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_cur == MODE_USR || mode_cur == MODE_SYS) |-> sr_rd_data == '0);

    assert_sr_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !sr_wr_en && !mode_chg |=> $stable(sr_rd_data));

    assert_low_shared_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (rd_a_idx >= IDX_W'(HI_FIRST) || rd_a_idx != $past(rd_a_idx)
                    || rd_a_data == $past(rd_a_data)));

    assert_slot15_a_R10: assert property (@(posedge clk) disable iff (rst)
        rd_a_idx == 4'd15 |-> rd_a_data == '0);

    assert_slot15_b_R10: assert property (@(posedge clk) disable iff (rst)
        rd_b_idx == 4'd15 |-> rd_b_data == '0);
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .SRW(SRW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_chg   (mode_chg),
    .mode_new   (mode_new),
    .rd_a_idx   (rd_a_idx),
    .rd_a_data  (rd_a_data),
    .rd_b_idx   (rd_b_idx),
    .rd_b_data  (rd_b_data),
    .wr_en      (wr_en),
    .sr_wr_en   (sr_wr_en),
    .sr_rd_data (sr_rd_data),
    .mode_cur   (mode_cur),
    .mode_err   (mode_err)
);

// File: tb/banked_regfile_tb_top.sv
`timescale 1ns/1ps
module banked_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        mode_chg;
    logic [4:0]  mode_new;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, sr_wr_en;
    logic [31:0] sr_wr_data, sr_rd_data;
    logic [4:0]  mode_cur;
    logic        mode_err;

    always #10 clk = ~clk;

    banked_regfile dut_i (
        .clk(clk), .rst(rst), .mode_chg(mode_chg), .mode_new(mode_new),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
        .mode_cur(mode_cur), .mode_err(mode_err)
    );

    // Reference model: a flat array of physical slots
    logic [31:0] phys_m [32];
    logic [31:0] sr_m   [5];
    logic [4:0]  mode_m;
    logic        err_m;
    int          errs   = 0;
    int          checks = 0;
    bit          done   = 0;
    logic [4:0]  legal_modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                     5'b10111, 5'b11011, 5'b11111};

    function automatic int bank_m(input logic [4:0] m);
        case (m)
            5'b10000, 5'b11111: return 0;
            5'b10001: return 1;
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return -1;
        endcase
    endfunction

    function automatic int slot(input logic [4:0] m, input logic [3:0] idx);
        if (idx < 8)  return int'(idx);
        if (idx < 13) return (m == 5'b10001) ? 15 + int'(idx) - 8 : int'(idx);
        if (idx < 15) return 20 + bank_m(m) * 2 + int'(idx) - 13;
        return -1;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [3:0] idx);
        int s = slot(mode_m, idx);
        return (s < 0) ? 32'h0 : phys_m[s];
    endfunction

    function automatic string tag_of(input logic [3:0] idx);
        if (idx < 8)  return "R2";
        if (idx < 13) return "R4";
        if (idx < 15) return "R3";
        return "R10";
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        int b = bank_m(mode_m);
        chk(tag_of(rd_a_idx), rd_a_data, exp_rd(rd_a_idx));
        chk(tag_of(rd_b_idx), rd_b_data, exp_rd(rd_b_idx));
        if (b > 0) chk("R7", sr_rd_data, sr_m[b - 1]);
        else       chk("R8", sr_rd_data, 32'h0);
        chk("R5", {27'h0, mode_cur}, {27'h0, mode_m});
        chk("R9", {31'h0, mode_err}, {31'h0, err_m});
    endtask

    task automatic cyc(input bit mc, input logic [4:0] nm, input bit we,
                       input logic [3:0] wi, input logic [31:0] wd,
                       input bit se, input logic [31:0] sd,
                       input logic [3:0] ra, input logic [3:0] rb);
        int s;
        @(negedge clk);
        mode_chg = mc; mode_new = nm; wr_en = we; wr_idx = wi; wr_data = wd;
        sr_wr_en = se; sr_wr_data = sd; rd_a_idx = ra; rd_b_idx = rb;
        #1;
        compare();
        @(posedge clk);
        if (we) begin
            s = slot(mode_m, wi);
            if (s >= 0) phys_m[s] = wd;
        end
        if (se && bank_m(mode_m) > 0) sr_m[bank_m(mode_m) - 1] = sd;
        err_m = mc && bank_m(nm) < 0;
        if (mc && bank_m(nm) >= 0) mode_m = nm;
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] b);
        cyc(0, 5'b0, 0, 4'd0, 32'h0, 0, 32'h0, a, b);
    endtask

    task automatic go(input logic [4:0] m);
        cyc(1, m, 0, 4'd0, 32'h0, 0, 32'h0, 4'd0, 4'd13);
    endtask

    task automatic wr(input logic [3:0] i, input logic [31:0] d);
        cyc(0, 5'b0, 1, i, d, 0, 32'h0, i, 4'd14);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) phys_m[i] = '0;
        for (int i = 0; i < 5; i++) sr_m[i] = '0;
        mode_m = 5'b10011; err_m = 0;
        rst = 1; mode_chg = 0; mode_new = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
        sr_wr_en = 0; sr_wr_data = 0; rd_a_idx = 0; rd_b_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        for (int i = 0; i < 16; i += 2) begin
            rd(4'(i), 4'(i + 1));
            chk("R1", rd_a_data, 32'h0);
            chk("R1", rd_b_data, 32'h0);
        end
        chk("R1", {27'h0, mode_cur}, {27'h0, 5'b10011});
        chk("R1", {31'h0, mode_err}, 32'h0);

        // R2/R3/R4: fill registers in several modes, then read them back
        for (int i = 0; i < 15; i++) wr(4'(i), 32'h100 + i);
        go(5'b10001);
        for (int i = 8; i < 15; i++) wr(4'(i), 32'hF00 + i);
        for (int i = 0; i < 15; i++) rd(4'(i), 4'(14 - i));
        rd(4'd3, 4'd9);
        chk("R2", rd_a_data, 32'h103);
        chk("R4", rd_b_data, 32'hF09);
        go(5'b10000);
        rd(4'd9, 4'd13);
        chk("R4", rd_a_data, 32'h109);
        go(5'b11111);
        wr(4'd13, 32'h5A5A);
        go(5'b10000);
        rd(4'd13, 4'd0);
        chk("R3", rd_a_data, 32'h5A5A);
        go(5'b10011);
        rd(4'd13, 4'd14);
        chk("R5", rd_a_data, 32'h10D);

        // R6: write during a switch lands in the old bank
        go(5'b10010);
        wr(4'd13, 32'h1313);
        cyc(1, 5'b10001, 1, 4'd13, 32'hBEEF, 0, 32'h0, 4'd13, 4'd13);
        rd(4'd13, 4'd0);
        chk("R6", rd_a_data, 32'hF0D);
        go(5'b10010);
        rd(4'd13, 4'd0);
        chk("R6", rd_a_data, 32'hBEEF);

        // R7/R8: saved status words
        cyc(0, 5'b0, 0, 4'd0, 32'h0, 1, 32'hAAAA0002, 4'd0, 4'd0);
        go(5'b10000);
        cyc(0, 5'b0, 0, 4'd0, 32'h0, 1, 32'hDEAD0000, 4'd0, 4'd0);
        rd(4'd0, 4'd0);
        chk("R8", sr_rd_data, 32'h0);
        go(5'b10010);
        rd(4'd0, 4'd0);
        chk("R7", sr_rd_data, 32'hAAAA0002);

        // R9: illegal mode codes
        cyc(1, 5'b00000, 1, 4'd14, 32'h7777, 0, 32'h0, 4'd0, 4'd0);
        rd(4'd14, 4'd13);
        chk("R9", {31'h0, mode_err}, 32'h1);
        chk("R9", {27'h0, mode_cur}, {27'h0, 5'b10010});
        cyc(1, 5'b10100, 0, 4'd0, 32'h0, 0, 32'h0, 4'd13, 4'd0);
        rd(4'd13, 4'd0);
        chk("R9", rd_a_data, 32'hBEEF);

        // R10: index 15
        wr(4'd15, 32'hFFFF_FFFF);
        rd(4'd15, 4'd15);
        chk("R10", rd_a_data, 32'h0);

        // Mixed random traffic
        for (int n = 0; n < 4000; n++) begin
            bit mc = ($urandom % 6) == 0;
            logic [4:0] nm = (($urandom % 10) == 0) ? 5'($urandom) : legal_modes[$urandom % 7];
            cyc(mc, nm, $urandom % 2 == 0, 4'($urandom), $urandom,
                $urandom % 4 == 0, $urandom, 4'($urandom), 4'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule